// File: doc/BRIEF.md
# Bank Mode Controller

This block keeps the operating mode of every bank in a banked non-volatile memory. A bank is always in one of three modes: plain read, busy (an embedded program or erase command owns the bank), or overlay (a small register space takes the place of one sector of the bank). Decoded requests arrive one per cycle with a target bank: start a command, enter overlay, leave overlay, command finished, reset, and program inside the overlay area. The block accepts a request only when it keeps the device legal. At most one bank may be away from read mode at any moment. A request that is not accepted changes nothing and raises a one-cycle error pulse.

A host read port asks about one bank and sector at a time. The block answers at once whether an array read is allowed, whether only a status read may be served, and whether the address falls on the overlaid sector. A program started inside the overlay area parks the overlay bank in busy mode. When that program finishes, the bank goes back to overlay with the same sector still selected. A program aimed at the protected factory/identification part of the overlay is refused.

Top module: `bank_mode_ctrl`

## Requirements
- R1: `bankMode[2*i+1:2*i]` holds the mode of bank i, coded 0 = read, 1 = busy, 2 = overlay. After reset every field is 0. Op code 1 (start command) moves an idle device's target bank to busy, and op code 2 (enter overlay) moves it to overlay.
- R2: At no time is more than one bank in a mode other than read.
- R3: Op code 1 or 2 issued while any bank is busy or overlaid is ignored: `bankMode` is unchanged and `reqErr` is 1 in the following cycle.
- R4: Op code 5 (reset), as well as a low `rstN`, returns every bank to read mode. The op code 5 request raises no error.
- R5: A read to a busy bank gives `rdAllow` = 0 unless `rdStatus` is 1, and `rdStatusOnly` = 1. Reads to every other bank at the same time give `rdAllow` = 1 and `rdStatusOnly` = 0.
- R6: While a bank is overlaid, reads to every bank give `rdAllow` = 1. `rdOverlayHit` is 1 only when `rdBank` is the overlaid bank and `rdSector` equals the sector given with op code 2.
- R7: Op code 6 (overlay program) with `reqProtected` = 0 on the overlaid bank makes that bank busy. The next op code 4 (command done) on it returns it to overlay with the same sector selected.
- R8: Op code 6 with `reqProtected` = 1 leaves `bankMode` unchanged and raises `reqErr`.
- R9: Op code 4 on a bank made busy by op code 1 returns it to read. Op code 3 (leave overlay) on the overlaid bank returns it to read.
- R10: Op code 3 on a bank that is not overlaid, op code 4 on a bank that is not busy, and op code 6 on a bank that is not overlaid are each ignored with `reqErr`.
- R11: `reqErr` is a registered pulse. It is high for exactly the one cycle after a refused request and low after an accepted request, after op codes 0 and 7, and when `reqValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| reqValid | input | 1 | A request is present this cycle |
| reqOp | input | 3 | Request op code (0 none, 1 start command, 2 enter overlay, 3 leave overlay, 4 command done, 5 reset, 6 overlay program, 7 none) |
| reqBank | input | BANK_W | Target bank of the request |
| reqSector | input | SECT_W | Sector to overlay (used with op code 2) |
| reqProtected | input | 1 | Overlay program targets the protected region (used with op code 6) |
| rdValid | input | 1 | A host read is being looked up |
| rdBank | input | BANK_W | Bank of the host read |
| rdSector | input | SECT_W | Sector of the host read |
| rdStatus | input | 1 | The host read is a status-register read |
| bankMode | output | 2*NUM_BANKS | Packed per-bank mode fields |
| rdAllow | output | 1 | The host read may be served |
| rdStatusOnly | output | 1 | The addressed bank is busy, so only status can be read |
| rdOverlayHit | output | 1 | The host read falls on the overlaid sector |
| reqErr | output | 1 | A request was refused in the previous cycle |

## Verification
`bankMode` and `reqErr` come from registers. Both change on the clock edge that samples a request, so they are due one edge after it. The bench therefore drives each request at a falling edge and compares the result at the next falling edge. It then waits one more cycle to confirm that `reqErr` has dropped. The read flags are purely combinational from the current modes, so the bench sets the read inputs and compares them a short delay later within the same cycle, with no clock edge between.

// File: rtl/bank_mode_pkg.sv
package bank_mode_pkg;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_BUSY = 2'd1,
    MODE_OVL  = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_START_CMD = 3'd1,
    OP_ENTER_OVL = 3'd2,
    OP_LEAVE_OVL = 3'd3,
    OP_CMD_DONE  = 3'd4,
    OP_RESET     = 3'd5,
    OP_PROG_OVL  = 3'd6,
    OP_SPARE     = 3'd7
  } op_e;

  // Strobes from the decision logic to the mode registers.
  typedef struct packed {
    logic goBusy;
    logic goOvl;
    logic goRead;
    logic clrAll;
    logic latchSector;
    logic setResume;
    logic flagErr;
  } strobe_t;

endpackage

// File: rtl/bank_mode_ctl.sv
module bank_mode_ctl
  import bank_mode_pkg::*;
(
  input  logic       reqValid,
  input  logic [2:0] reqOp,
  input  logic       reqProtected,
  input  mode_e      tgtMode,
  input  logic       anyActive,
  input  logic       resumeOvl,
  output strobe_t    stb
);

  always_comb begin
    stb = '0;
    if (reqValid) begin
      unique case (op_e'(reqOp))
        OP_START_CMD: begin
          if (!anyActive) stb.goBusy = 1'b1;
          else            stb.flagErr = 1'b1;
        end
        OP_ENTER_OVL: begin
          if (!anyActive) begin
            stb.goOvl       = 1'b1;
            stb.latchSector = 1'b1;
          end else begin
            stb.flagErr = 1'b1;
          end
        end
        OP_LEAVE_OVL: begin
          if (tgtMode == MODE_OVL) stb.goRead = 1'b1;
          else                     stb.flagErr = 1'b1;
        end
        OP_CMD_DONE: begin
          if (tgtMode == MODE_BUSY) begin
            if (resumeOvl) stb.goOvl  = 1'b1;
            else           stb.goRead = 1'b1;
          end else begin
            stb.flagErr = 1'b1;
          end
        end
        OP_RESET: stb.clrAll = 1'b1;
        OP_PROG_OVL: begin
          if (tgtMode == MODE_OVL && !reqProtected) begin
            stb.goBusy    = 1'b1;
            stb.setResume = 1'b1;
          end else begin
            stb.flagErr = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bank_mode_dp.sv
module bank_mode_dp
  import bank_mode_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS),
  parameter int SECT_W    = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  logic [BANK_W-1:0]      reqBank,
  input  logic [SECT_W-1:0]      reqSector,
  input  logic                   rdValid,
  input  logic [BANK_W-1:0]      rdBank,
  input  logic [SECT_W-1:0]      rdSector,
  input  logic                   rdStatus,
  output mode_e                  tgtMode,
  output logic                   anyActive,
  output logic                   resumeOvl,
  output logic [2*NUM_BANKS-1:0] bankMode,
  output logic                   rdAllow,
  output logic                   rdStatusOnly,
  output logic                   rdOverlayHit,
  output logic                   reqErr
);

  localparam logic [BANK_W:0] BANK_LIMIT = (BANK_W+1)'(NUM_BANKS);

  mode_e               modeQ [NUM_BANKS];
  logic [NUM_BANKS-1:0] actVec;
  logic [SECT_W-1:0]   ovlSectorQ;
  logic                resumeQ;
  logic                errQ;
  mode_e               rdMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++) modeQ[b] <= MODE_READ;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (stb.clrAll) begin
          modeQ[b] <= MODE_READ;
        end else if (reqBank == BANK_W'(b)) begin
          if (stb.goBusy)      modeQ[b] <= MODE_BUSY;
          else if (stb.goOvl)  modeQ[b] <= MODE_OVL;
          else if (stb.goRead) modeQ[b] <= MODE_READ;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovlSectorQ <= '0;
      resumeQ    <= 1'b0;
      errQ       <= 1'b0;
    end else begin
      errQ <= stb.flagErr;
      if (stb.latchSector) ovlSectorQ <= reqSector;
      if (stb.clrAll || stb.goRead || stb.goOvl) resumeQ <= 1'b0;
      else if (stb.setResume)                    resumeQ <= 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      assign actVec[i]         = (modeQ[i] != MODE_READ);
      assign bankMode[2*i +: 2] = modeQ[i];
    end
  endgenerate

  assign anyActive = |actVec;
  assign resumeOvl = resumeQ;
  assign reqErr    = errQ;
  assign tgtMode   = ({1'b0, reqBank} < BANK_LIMIT) ? modeQ[reqBank] : MODE_READ;
  assign rdMode    = ({1'b0, rdBank} < BANK_LIMIT) ? modeQ[rdBank] : MODE_READ;

  assign rdAllow      = rdValid && ((rdMode != MODE_BUSY) || rdStatus);
  assign rdStatusOnly = rdValid && (rdMode == MODE_BUSY);
  assign rdOverlayHit = rdValid && (rdMode == MODE_OVL) && (rdSector == ovlSectorQ);

endmodule

// File: rtl/bank_mode_ctrl.sv
module bank_mode_ctrl
  import bank_mode_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS),
  parameter int SECT_W    = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [2:0]             reqOp,
  input  logic [BANK_W-1:0]      reqBank,
  input  logic [SECT_W-1:0]      reqSector,
  input  logic                   reqProtected,
  input  logic                   rdValid,
  input  logic [BANK_W-1:0]      rdBank,
  input  logic [SECT_W-1:0]      rdSector,
  input  logic                   rdStatus,
  output logic [2*NUM_BANKS-1:0] bankMode,
  output logic                   rdAllow,
  output logic                   rdStatusOnly,
  output logic                   rdOverlayHit,
  output logic                   reqErr
);

  strobe_t stb;
  mode_e   tgtMode;
  logic    anyActive;
  logic    resumeOvl;

  bank_mode_ctl i_ctl (
    .reqValid    (reqValid),
    .reqOp       (reqOp),
    .reqProtected(reqProtected),
    .tgtMode     (tgtMode),
    .anyActive   (anyActive),
    .resumeOvl   (resumeOvl),
    .stb         (stb)
  );

  bank_mode_dp #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W),
    .SECT_W   (SECT_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .reqBank     (reqBank),
    .reqSector   (reqSector),
    .rdValid     (rdValid),
    .rdBank      (rdBank),
    .rdSector    (rdSector),
    .rdStatus    (rdStatus),
    .tgtMode     (tgtMode),
    .anyActive   (anyActive),
    .resumeOvl   (resumeOvl),
    .bankMode    (bankMode),
    .rdAllow     (rdAllow),
    .rdStatusOnly(rdStatusOnly),
    .rdOverlayHit(rdOverlayHit),
    .reqErr      (reqErr)
  );

endmodule

// File: rtl/bank_mode_chk.sv
module bank_mode_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS),
  parameter int SECT_W    = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic [2:0]             reqOp,
  input logic [BANK_W-1:0]      reqBank,
  input logic                   reqProtected,
  input logic                   rdValid,
  input logic [BANK_W-1:0]      rdBank,
  input logic                   rdStatus,
  input logic [2*NUM_BANKS-1:0] bankMode,
  input logic                   rdAllow,
  input logic                   rdStatusOnly,
  input logic                   reqErr
);

  logic [NUM_BANKS-1:0] nonRead;
  logic                 busyAny;
  logic [1:0]           rdBankMode;
  logic                 enterReq;

  generate
    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_act
      assign nonRead[i] = (bankMode[2*i +: 2] != 2'd0);
    end
  endgenerate

  assign busyAny    = |nonRead;
  assign rdBankMode = bankMode[2*rdBank +: 2];
  assign enterReq   = reqValid && (reqOp == 3'd1 || reqOp == 3'd2);

  // R2
  a_r2_single_active: assert property (@(posedge clk) disable iff (!rstN)
    $countones(nonRead) <= 1);

  // R3
  a_r3_enter_refused: assert property (@(posedge clk) disable iff (!rstN)
    enterReq && busyAny |=> $stable(bankMode) && reqErr);

  // R4
  a_r4_reset_op: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqOp == 3'd5 |=> bankMode == '0 && !reqErr);

  // R5
  a_r5_busy_read: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && rdBankMode == 2'd1 |-> rdStatusOnly && (rdAllow == rdStatus));

  // R8
  a_r8_protected_prog: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqOp == 3'd6 && reqProtected |=> $stable(bankMode) && reqErr);

  // R11
  a_r11_no_err_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !reqErr);

endmodule

bind bank_mode_ctrl bank_mode_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W),
  .SECT_W   (SECT_W)
) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqOp       (reqOp),
  .reqBank     (reqBank),
  .reqProtected(reqProtected),
  .rdValid     (rdValid),
  .rdBank      (rdBank),
  .rdStatus    (rdStatus),
  .bankMode    (bankMode),
  .rdAllow     (rdAllow),
  .rdStatusOnly(rdStatusOnly),
  .reqErr      (reqErr)
);

// File: tb/test_bank_mode_ctrl.sv
module test_bank_mode_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_BANKS  = 4;
  localparam int BANK_W     = 2;
  localparam int SECT_W     = 3;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   reqValid = 1'b0;
  logic [2:0]             reqOp = '0;
  logic [BANK_W-1:0]      reqBank = '0;
  logic [SECT_W-1:0]      reqSector = '0;
  logic                   reqProtected = 1'b0;
  logic                   rdValid = 1'b0;
  logic [BANK_W-1:0]      rdBank = '0;
  logic [SECT_W-1:0]      rdSector = '0;
  logic                   rdStatus = 1'b0;
  logic [2*NUM_BANKS-1:0] bankMode;
  logic                   rdAllow;
  logic                   rdStatusOnly;
  logic                   rdOverlayHit;
  logic                   reqErr;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  bank_mode_ctrl #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W),
    .SECT_W   (SECT_W)
  ) i_bank_mode_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqOp       (reqOp),
    .reqBank     (reqBank),
    .reqSector   (reqSector),
    .reqProtected(reqProtected),
    .rdValid     (rdValid),
    .rdBank      (rdBank),
    .rdSector    (rdSector),
    .rdStatus    (rdStatus),
    .bankMode    (bankMode),
    .rdAllow     (rdAllow),
    .rdStatusOnly(rdStatusOnly),
    .rdOverlayHit(rdOverlayHit),
    .reqErr      (reqErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the sampling edge.
  task automatic doReq(input logic [2:0] op, input int bank, input int sector, input logic prot);
    reqValid     = 1'b1;
    reqOp        = op;
    reqBank      = bank[BANK_W-1:0];
    reqSector    = sector[SECT_W-1:0];
    reqProtected = prot;
    @(negedge clk);
    reqValid     = 1'b0;
    reqOp        = 3'd0;
    reqProtected = 1'b0;
  endtask

  task automatic lookRead(input int bank, input int sector, input logic status);
    rdValid  = 1'b1;
    rdBank   = bank[BANK_W-1:0];
    rdSector = sector[SECT_W-1:0];
    rdStatus = status;
    #1;
  endtask

  task automatic idleErr(input string tag);
    @(negedge clk);
    chk(tag, {31'd0, reqErr}, 32'd0);
  endtask

  task automatic testResetState();
    chk("R1 reset modes", {24'd0, bankMode}, 32'h0);
    chk("R11 reset err", {31'd0, reqErr}, 32'd0);
  endtask

  task automatic testBusy();
    doReq(3'd1, 2, 0, 1'b0);
    chk("R1 start cmd bank2", {24'd0, bankMode}, 32'h10);
    chk("R11 accepted no err", {31'd0, reqErr}, 32'd0);
    lookRead(2, 0, 1'b0);
    chk("R5 busy array read", {30'd0, rdAllow, rdStatusOnly}, 32'h1);
    lookRead(2, 0, 1'b1);
    chk("R5 busy status read", {30'd0, rdAllow, rdStatusOnly}, 32'h3);
    lookRead(0, 0, 1'b0);
    chk("R5 other bank read", {30'd0, rdAllow, rdStatusOnly}, 32'h2);
    doReq(3'd1, 1, 0, 1'b0);
    chk("R3 second cmd refused", {23'd0, reqErr, bankMode}, 32'h110);
    chk("R2 single active bank", {24'd0, bankMode}, 32'h10);
    idleErr("R11 err pulse drops");
    doReq(3'd2, 0, 1, 1'b0);
    chk("R3 overlay while busy refused", {23'd0, reqErr, bankMode}, 32'h110);
    doReq(3'd4, 1, 0, 1'b0);
    chk("R10 done on idle bank", {23'd0, reqErr, bankMode}, 32'h110);
    doReq(3'd4, 2, 0, 1'b0);
    chk("R9 done returns to read", {23'd0, reqErr, bankMode}, 32'h000);
  endtask

  task automatic testOverlay();
    doReq(3'd2, 1, 5, 1'b0);
    chk("R1 enter overlay bank1", {23'd0, reqErr, bankMode}, 32'h008);
    lookRead(1, 5, 1'b0);
    chk("R6 overlaid sector hit", {30'd0, rdAllow, rdOverlayHit}, 32'h3);
    lookRead(1, 3, 1'b0);
    chk("R6 other sector array", {30'd0, rdAllow, rdOverlayHit}, 32'h2);
    lookRead(3, 5, 1'b0);
    chk("R6 other bank same sector", {30'd0, rdAllow, rdOverlayHit}, 32'h2);
    doReq(3'd1, 0, 0, 1'b0);
    chk("R3 cmd during overlay refused", {23'd0, reqErr, bankMode}, 32'h108);
    doReq(3'd6, 1, 0, 1'b1);
    chk("R8 protected program refused", {23'd0, reqErr, bankMode}, 32'h108);
    doReq(3'd6, 0, 0, 1'b0);
    chk("R10 program on plain bank", {23'd0, reqErr, bankMode}, 32'h108);
    doReq(3'd6, 1, 0, 1'b0);
    chk("R7 overlay program busy", {23'd0, reqErr, bankMode}, 32'h004);
    lookRead(1, 5, 1'b0);
    chk("R5 overlay bank busy read", {29'd0, rdAllow, rdStatusOnly, rdOverlayHit}, 32'h2);
    doReq(3'd4, 1, 0, 1'b0);
    chk("R7 done resumes overlay", {23'd0, reqErr, bankMode}, 32'h008);
    lookRead(1, 5, 1'b0);
    chk("R7 sector kept", {31'd0, rdOverlayHit}, 32'd1);
    doReq(3'd3, 1, 0, 1'b0);
    chk("R9 leave overlay", {23'd0, reqErr, bankMode}, 32'h000);
    doReq(3'd3, 1, 0, 1'b0);
    chk("R10 leave when not overlaid", {23'd0, reqErr, bankMode}, 32'h100);
  endtask

  task automatic testResets();
    doReq(3'd1, 3, 0, 1'b0);
    chk("R1 start cmd bank3", {24'd0, bankMode}, 32'h40);
    doReq(3'd5, 1, 0, 1'b0);
    chk("R4 reset op", {23'd0, reqErr, bankMode}, 32'h000);
    doReq(3'd1, 0, 0, 1'b0);
    chk("R4 cmd after reset accepted", {23'd0, reqErr, bankMode}, 32'h001);
    doReq(3'd4, 0, 0, 1'b0);
    doReq(3'd2, 0, 2, 1'b0);
    chk("R1 overlay bank0", {24'd0, bankMode}, 32'h02);
    rstN = 1'b0;
    #1;
    chk("R4 hardware reset", {24'd0, bankMode}, 32'h00);
    @(negedge clk);
    rstN = 1'b1;
    doReq(3'd0, 0, 0, 1'b0);
    chk("R11 op0 no err", {23'd0, reqErr, bankMode}, 32'h000);
    doReq(3'd7, 2, 0, 1'b0);
    chk("R11 op7 no err", {23'd0, reqErr, bankMode}, 32'h000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    testBusy();
    testOverlay();
    testResets();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule